// File: doc/BRIEF.md
# Two-Channel DRAM Traffic Counter

This block sits in front of a two-channel memory controller. It accepts one memory request per cycle over a valid/ready handshake. Each request carries a physical address, a read/write flag, a partial-line flag and a source tag. The block steers the request to a channel and a rank. It turns the request into the full-line column commands that the memory bus actually carries, because every bus transfer is one 64-byte burst to a single rank.

A partial read costs one full-line read. A partial write costs a full-line read followed by a full-line write. While that second command is issued, the request port is held off for one cycle.

Two kinds of saturating counters observe the traffic. Column-command counters are indexed by command type, channel and rank. Request counters are indexed by originating source. The two kinds are kept apart, so a single partial write adds one request but two commands. Software reads the counters through a combinational read port and zeroes all of them with a clear strobe.

Top module: `dram_traffic_counter`

## Requirements
- R1: After reset all counters read zero, `cmd_valid_o` is low and `req_ready_o` is high.
- R2: A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both high. A full-line read or a full-line write yields exactly one command, valid in the cycle after acceptance, with `cmd_write_o` equal to the request's write flag.
- R3: A partial read yields exactly one full-line read command (`cmd_write_o` = 0) in the cycle after acceptance.
- R4: A partial write yields a read command in the cycle after acceptance and a write command to the same channel, rank and line in the following cycle. `req_ready_o` is low during the read-command cycle and high again in the write-command cycle.
- R5: `cmd_chan_o` equals address bit 6. `cmd_addr_o` is the request address with bits 5:0 cleared.
- R6: `cmd_rank_o` follows `cfg_ranks_i`, sampled at acceptance. When `cfg_ranks_i` is 2, the rank is {0, address bit 7}. When it is 4, the rank is address bits 8:7. For any other value the rank is 0.
- R7: Read-port addresses 0 to 15 hold the column-command counters at index write*8 + channel*4 + rank. Each counter increments once per emitted command, on the clock edge that ends the command's valid cycle.
- R8: Read-port addresses 16, 17 and 18 count accepted requests from source codes 0 (graphics), 1 (core) and 2 (I/O). The count rises once per request however many commands the request expands into. Source code 3 is counted by no request counter, but its commands are still issued and counted.
- R9: Every counter saturates at all-ones and holds that value under further increments.
- R10: `clr_i` high at a clock edge zeroes every counter. The clear takes priority over any increment on the same edge.
- R11: `rd_data_o` shows the selected counter as of the last clock edge, combinationally from `rd_addr_i`. An increment becomes visible only after its edge. Addresses 19 to 31 read zero.
- R12: No request is accepted while `req_ready_o` is low. A request held valid through that cycle is accepted on the next edge where ready is high, and its command follows the pending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_ranks_i | input | 3 | Ranks per channel (2 or 4 select rank bits) |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request may be accepted |
| req_addr_i | input | ADDR_W | Physical address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_partial_i | input | 1 | Access covers less than a full line |
| req_src_i | input | 2 | Source: 0 graphics, 1 core, 2 I/O, 3 none |
| cmd_valid_o | output | 1 | Column command valid this cycle |
| cmd_write_o | output | 1 | 1 = write command, 0 = read command |
| cmd_chan_o | output | 1 | Target channel |
| cmd_rank_o | output | 2 | Target rank within channel |
| cmd_addr_o | output | ADDR_W | Line-aligned address |
| clr_i | input | 1 | Clear all counters |
| rd_addr_i | input | 5 | Counter select |
| rd_data_o | output | CNT_W | Selected counter value |

## Verification
The bench sweeps every combination of address bits 8:6, write flag, partial flag, source code and several rank configurations. It checks every emitted command, then compares all counters against arithmetic totals. A design that skipped the read half of a partial write, or counted it as a request, would be off in the read counters or in the request counters. A design that took the rank from the wrong bit, or ignored the configuration, would scatter counts across the wrong rank slots. A narrow counter width drives the busiest counters past all-ones, which exposes counters that wrap instead of holding. The bench then targets a clear on the same edge as an increment, a request held valid across the ready-low cycle, and the one-edge lag of the read port. Designs that let the increment win, accept the held request early, or register the read data a second time would each fail there.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int NUM_CHAN    = 2;
  localparam int MAX_RANK    = 4;
  localparam int RANK_W      = $clog2(MAX_RANK);
  localparam int NUM_CMD_CNT = 2 * NUM_CHAN * MAX_RANK;
  localparam int NUM_SRC     = 3;
  localparam int NUM_CNT     = NUM_CMD_CNT + NUM_SRC;
  localparam int RD_AW       = $clog2(NUM_CNT);
  localparam int RD_DEPTH    = 1 << RD_AW;
  localparam int KEY_W       = 1 + 1 + RANK_W;

  typedef enum logic [1:0] {
    SRC_GFX  = 2'd0,
    SRC_CORE = 2'd1,
    SRC_IO   = 2'd2,
    SRC_NONE = 2'd3
  } src_e;

  // packed order doubles as the command-counter index
  typedef struct packed {
    logic              write;
    logic              chan;
    logic [RANK_W-1:0] rank;
  } cmd_key_t;
endpackage

// File: rtl/dtc_steer.sv
module dtc_steer
  import dtc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        cfg_ranks_i,
  output logic              chan_o,
  output logic [RANK_W-1:0] rank_o,
  output logic [ADDR_W-1:0] line_o
);
  localparam int RANK_LSB = LINE_BITS + 1;

  assign chan_o = addr_i[LINE_BITS];
  assign line_o = {addr_i[ADDR_W-1:LINE_BITS], {LINE_BITS{1'b0}}};

  always_comb begin
    unique case (cfg_ranks_i)
      3'd2:    rank_o = {1'b0, addr_i[RANK_LSB]};
      3'd4:    rank_o = addr_i[RANK_LSB+RANK_W-1:RANK_LSB];
      default: rank_o = '0;
    endcase
  end
endmodule

// File: rtl/dtc_expand.sv
module dtc_expand
  import dtc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_partial_i,
  input  logic              chan_i,
  input  logic [RANK_W-1:0] rank_i,
  input  logic [ADDR_W-1:0] line_i,
  output logic              ready_o,
  output logic              accept_o,
  output logic              cmd_valid_o,
  output cmd_key_t          cmd_key_o,
  output logic [ADDR_W-1:0] cmd_addr_o
);
  logic              pend_q;
  logic              valid_q;
  cmd_key_t          key_q;
  logic [ADDR_W-1:0] addr_q;

  assign ready_o  = ~pend_q;
  assign accept_o = req_valid_i & ~pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
      key_q   <= '0;
      addr_q  <= '0;
    end else if (pend_q) begin
      // second half of a partial write: same line, write command
      pend_q      <= 1'b0;
      valid_q     <= 1'b1;
      key_q.write <= 1'b1;
    end else if (accept_o) begin
      pend_q      <= req_write_i & req_partial_i;
      valid_q     <= 1'b1;
      key_q.write <= req_write_i & ~req_partial_i;
      key_q.chan  <= chan_i;
      key_q.rank  <= rank_i;
      addr_q      <= line_i;
    end else begin
      valid_q <= 1'b0;
    end
  end

  assign cmd_valid_o = valid_q;
  assign cmd_key_o   = key_q;
  assign cmd_addr_o  = addr_q;
endmodule

// File: rtl/dtc_sat_counter.sv
module dtc_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_o <= '0;
    else if (clr_i)               cnt_o <= '0;
    else if (inc_i && !(&cnt_o))  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/dram_traffic_counter.sv
module dram_traffic_counter
  import dtc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 32,
  parameter int LINE_BITS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cfg_ranks_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              req_partial_i,
  input  logic [1:0]        req_src_i,
  output logic              cmd_valid_o,
  output logic              cmd_write_o,
  output logic              cmd_chan_o,
  output logic [1:0]        cmd_rank_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  input  logic              clr_i,
  input  logic [4:0]        rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o
);
  logic              st_chan;
  logic [RANK_W-1:0] st_rank;
  logic [ADDR_W-1:0] st_line;
  logic              accept;
  cmd_key_t          cmd_key;
  logic [CNT_W-1:0]  cnt_arr [RD_DEPTH];

  dtc_steer #(.ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS)) u_steer (
    .addr_i      (req_addr_i),
    .cfg_ranks_i (cfg_ranks_i),
    .chan_o      (st_chan),
    .rank_o      (st_rank),
    .line_o      (st_line)
  );

  dtc_expand #(.ADDR_W(ADDR_W)) u_expand (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_write_i   (req_write_i),
    .req_partial_i (req_partial_i),
    .chan_i        (st_chan),
    .rank_i        (st_rank),
    .line_i        (st_line),
    .ready_o       (req_ready_o),
    .accept_o      (accept),
    .cmd_valid_o   (cmd_valid_o),
    .cmd_key_o     (cmd_key),
    .cmd_addr_o    (cmd_addr_o)
  );

  assign cmd_write_o = cmd_key.write;
  assign cmd_chan_o  = cmd_key.chan;
  assign cmd_rank_o  = cmd_key.rank;

  for (genvar i = 0; i < RD_DEPTH; i++) begin : g_cnt
    if (i < NUM_CMD_CNT) begin : g_cmd
      dtc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr_i),
        .inc_i  (cmd_valid_o && (cmd_key == KEY_W'(i))),
        .cnt_o  (cnt_arr[i])
      );
    end else if (i < NUM_CNT) begin : g_req
      dtc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr_i),
        .inc_i  (accept && (req_src_i == 2'(i - NUM_CMD_CNT))),
        .cnt_o  (cnt_arr[i])
      );
    end else begin : g_pad
      assign cnt_arr[i] = '0;
    end
  end

  assign rd_data_o = cnt_arr[rd_addr_i];
endmodule

// File: rtl/dtc_checker.sv
module dtc_checker #(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 32,
  parameter int LINE_BITS = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_write_i,
  input logic              req_partial_i,
  input logic              cmd_valid_o,
  input logic              cmd_write_o,
  input logic              cmd_chan_o,
  input logic [ADDR_W-1:0] cmd_addr_o,
  input logic              clr_i,
  input logic [4:0]        rd_addr_i,
  input logic [CNT_W-1:0]  rd_data_o
);
  logic acc;
  assign acc = req_valid_i && req_ready_o;

  a_r2_single_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !(req_write_i && req_partial_i) |=>
      cmd_valid_o && (cmd_write_o == $past(req_write_i)) && req_ready_o);

  a_r4_read_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && req_write_i && req_partial_i |=>
      cmd_valid_o && !cmd_write_o && !req_ready_o);

  a_r4_write_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> cmd_valid_o && cmd_write_o && req_ready_o);

  a_r5_chan_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (cmd_chan_o == $past(req_addr_i[LINE_BITS])) &&
            (cmd_addr_o[LINE_BITS-1:0] == '0));

  a_r9_hold_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && (&rd_data_o) |=> (rd_addr_i != $past(rd_addr_i)) || (&rd_data_o));

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> rd_data_o == '0);
endmodule

bind dram_traffic_counter dtc_checker #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_BITS(LINE_BITS)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .req_addr_i    (req_addr_i),
  .req_write_i   (req_write_i),
  .req_partial_i (req_partial_i),
  .cmd_valid_o   (cmd_valid_o),
  .cmd_write_o   (cmd_write_o),
  .cmd_chan_o    (cmd_chan_o),
  .cmd_addr_o    (cmd_addr_o),
  .clr_i         (clr_i),
  .rd_addr_i     (rd_addr_i),
  .rd_data_o     (rd_data_o)
);

// File: tb/dram_traffic_counter_test.sv
`timescale 1ns/1ps
module dram_traffic_counter_test;
  localparam int CW  = 6;
  localparam int MAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0]  cfg_ranks_i = 3'd1;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic        req_write_i = 1'b0;
  logic        req_partial_i = 1'b0;
  logic [1:0]  req_src_i = '0;
  logic        cmd_valid_o, cmd_write_o, cmd_chan_o;
  logic [1:0]  cmd_rank_o;
  logic [31:0] cmd_addr_o;
  logic        clr_i = 1'b0;
  logic [4:0]  rd_addr_i = '0;
  logic [CW-1:0] rd_data_o;

  int n_chk = 0;
  int n_bad = 0;
  int exp_cnt [19];

  always #4 clk = ~clk;

  dram_traffic_counter #(.CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_ranks_i(cfg_ranks_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_write_i(req_write_i),
    .req_partial_i(req_partial_i), .req_src_i(req_src_i),
    .cmd_valid_o(cmd_valid_o), .cmd_write_o(cmd_write_o),
    .cmd_chan_o(cmd_chan_o), .cmd_rank_o(cmd_rank_o),
    .cmd_addr_o(cmd_addr_o), .clr_i(clr_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void bump(input int i);
    if (exp_cnt[i] < MAX) exp_cnt[i]++;
  endfunction

  function automatic int exp_rank(input logic [31:0] a, input logic [2:0] cfg);
    if (cfg == 3'd2) return int'(a[7]);
    if (cfg == 3'd4) return int'(a[8:7]);
    return 0;
  endfunction

  task automatic rd_chk(input int idx, input int exp, input string tag);
    @(negedge clk);
    rd_addr_i = 5'(idx);
    #1;
    check(tag, rd_data_o, exp);
  endtask

  task automatic send(input logic [31:0] a, input logic w, input logic p,
                      input logic [1:0] s);
    int ch, rk;
    ch = int'(a[6]);
    rk = exp_rank(a, cfg_ranks_i);
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    req_valid_i = 1'b1; req_addr_i = a; req_write_i = w;
    req_partial_i = p; req_src_i = s;
    @(negedge clk);
    req_valid_i = 1'b0;
    check("R2 cmd valid", cmd_valid_o, 1);
    check("R3/R2 cmd type", cmd_write_o, w && !p);
    check("R5 channel", cmd_chan_o, ch);
    check("R6 rank", cmd_rank_o, rk);
    check("R5 line addr", cmd_addr_o, {a[31:6], 6'd0});
    if (s != 2'd3) bump(16 + int'(s)); // R8
    if (w && p) begin
      check("R4 ready low", req_ready_o, 0);
      bump(ch * 4 + rk); // R7
      @(negedge clk);
      check("R4 write valid", cmd_valid_o, 1);
      check("R4 write type", cmd_write_o, 1);
      check("R4 same channel", cmd_chan_o, ch);
      check("R4 same rank", cmd_rank_o, rk);
      check("R4 ready back", req_ready_o, 1);
      bump(8 + ch * 4 + rk);
    end else begin
      bump(int'(w) * 8 + ch * 4 + rk);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [2:0] cfgs [4];
    cfgs[0] = 3'd0; cfgs[1] = 3'd1; cfgs[2] = 3'd2; cfgs[3] = 3'd4;
    foreach (exp_cnt[i]) exp_cnt[i] = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 ready", req_ready_o, 1);
    check("R1 cmd idle", cmd_valid_o, 0);
    check("R1 counter", rd_data_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R12 no cmd while idle", cmd_valid_o, 0);

    // sweep: rank config x addr[8:6] x write x partial x source
    for (int c = 0; c < 4; c++) begin
      cfg_ranks_i = cfgs[c];
      for (int k = 0; k < 8; k++)
        for (int w = 0; w < 2; w++)
          for (int p = 0; p < 2; p++)
            for (int s = 0; s < 4; s++)
              send(32'h1234_5000 | 32'(k << 6) | 32'((k * 13 + s) & 63),
                   w[0], p[0], s[1:0]);
    end
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < 16; i++) rd_chk(i, exp_cnt[i], "R7 cmd counter");
    for (int i = 16; i < 19; i++) rd_chk(i, exp_cnt[i], "R8 req counter");
    rd_chk(16, MAX, "R9 saturated graphics");
    rd_chk(19, 0, "R11 unused addr 19");
    rd_chk(31, 0, "R11 unused addr 31");

    // more traffic into a saturated counter
    cfg_ranks_i = 3'd1;
    send(32'h0, 1'b0, 1'b0, 2'd0);
    rd_chk(16, MAX, "R9 holds at max");

    // clear
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
    foreach (exp_cnt[i]) exp_cnt[i] = 0;
    for (int i = 0; i < 19; i++) rd_chk(i, 0, "R10 cleared");

    // clear on the acceptance edge: request count lost, command count kept
    @(negedge clk);
    rd_addr_i = 5'd17;
    req_valid_i = 1'b1; req_addr_i = 32'h0; req_write_i = 1'b0;
    req_partial_i = 1'b0; req_src_i = 2'd1; clr_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0; clr_i = 1'b0;
    #1;
    check("R10 clear beats increment", rd_data_o, 0);
    rd_addr_i = 5'd0;
    #1;
    check("R11 not yet visible", rd_data_o, 0);
    rd_chk(0, 1, "R11 visible after edge");

    // R12: request held valid through the ready-low cycle
    cfg_ranks_i = 3'd2;
    @(negedge clk);
    req_valid_i = 1'b1; req_addr_i = 32'h40; req_write_i = 1'b1;
    req_partial_i = 1'b1; req_src_i = 2'd2;
    @(negedge clk);
    check("R12 read first", cmd_write_o, 0);
    check("R12 ready low", req_ready_o, 0);
    req_addr_i = 32'h80; req_write_i = 1'b0; req_partial_i = 1'b0;
    req_src_i = 2'd0;
    @(negedge clk);
    check("R12 pending write", cmd_write_o, 1);
    check("R12 pending write channel", cmd_chan_o, 1);
    @(negedge clk);
    req_valid_i = 1'b0;
    check("R12 held request valid", cmd_valid_o, 1);
    check("R12 held request type", cmd_write_o, 0);
    check("R12 held request rank", cmd_rank_o, 1);
    check("R12 held request channel", cmd_chan_o, 0);
    @(negedge clk);
    check("R12 nothing extra", cmd_valid_o, 0);
    rd_chk(16, 1, "R12 graphics once");
    rd_chk(18, 1, "R12 io once");
    rd_chk(4, 1, "R12 read ch1 r0");
    rd_chk(12, 1, "R12 write ch1 r0");
    rd_chk(1, 1, "R12 read ch0 r1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule